// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage with Selectable Latency and Turn-off

This block sits between the storage array of a synchronous SRAM and its data pins. Each clock edge it captures a command (read, write or deselect). After a read is captured, the array returns the addressed word during the following cycle. The block places that word on the output bus and decides, cycle by cycle, whether the bus drivers are on. An asynchronous output-enable input gates the drivers at all times.

Two static mode inputs shape the timing. `pipe_sel` picks the read latency:

- Low gives flow-through operation. The array word passes straight to the bus in the cycle after the command edge.
- High gives pipelined operation. An extra output register, loaded on the rising edge, delays the word by one cycle.

`dcd_sel` picks how long the bus stays on after a deselect that follows a read:

- Single-cycle deselect turns the bus off as soon as the deselect reaches the output stage.
- Dual-cycle deselect keeps the last read word on the bus for one more full cycle before turning off.

The mode inputs may change only while reset is asserted. The output bus has no back-pressure: there is no ready signal. A word appears for exactly the cycles given below, and the receiver must take it then. Deselected cycles and write cycles carry no data.

Top module: `rop_read_out`

## Requirements
- R1: While `rst_n` is low, and after it is released until a read reaches the output stage, `dq_en` is 0 and `dq_o` is 0. Asserting `rst_n` low turns the bus off at once, without waiting for a clock edge.
- R2: `cmd_i` is decoded as 2'b01 read, 2'b10 write and 2'b00 deselect. The spare code 2'b11 behaves exactly as a deselect, including the extra hold cycle in dual-cycle mode.
- R3: With `pipe_sel`=0, a read captured at edge k drives the bus for the cycle between edges k and k+1. During that cycle `dq_o` equals the `rd_word` presented in the same cycle.
- R4: With `pipe_sel`=1, the word presented on `rd_word` between edges k and k+1 is registered at edge k+1. It is driven on `dq_o` for the cycle between edges k+1 and k+2.
- R5: Back-to-back reads stream one word per cycle. Counting the cycle in which the first command is presented as cycle 1, four reads deliver data in cycles 2,3,4,5 in flow-through mode and in cycles 3,4,5,6 in pipelined mode.
- R6: A write never turns the bus on. When a write reaches the output stage, the bus is off for that cycle in every mode, even directly after a read.
- R7: With `dcd_sel`=0, a deselect turns the bus off in the cycle it reaches the output stage. This is the cycle right after the last read word.
- R8: With `dcd_sel`=1, the first deselect reaching the output stage after a read keeps the bus on for one more cycle, showing the same last read word. If the next stage is again a deselect, the bus turns off. The hold does not follow a write.
- R9: A read that follows a deselect or a write turns the bus on with the normal latency of R3 or R4. Read words then continue back to back with no gap.
- R10: `dq_en` is the synchronous drive state ANDed with `oe_i`, and it follows `oe_i` combinationally within a cycle. `dq_o` is 0 whenever `dq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_sel | input | 1 | 0 flow-through, 1 pipelined (static) |
| dcd_sel | input | 1 | 0 single-cycle deselect, 1 dual-cycle deselect (static) |
| oe_i | input | 1 | Asynchronous output enable, active high |
| cmd_i | input | 2 | Command captured at each edge (see R2) |
| rd_word | input | DATA_W | Array word for the read captured at the previous edge |
| dq_o | output | DATA_W | Output data, zero when not driven |
| dq_en | output | 1 | Bus driver enable |

## Verification
The assertions rest on three assumptions about the inputs:

- `pipe_sel` and `dcd_sel` change only while reset is asserted.
- `cmd_i` and `rd_word` are stable around each rising edge.
- The array word for a read is present throughout the cycle after that read is captured.

The stimulus meets these assumptions in the following ways. It changes every input at the falling edge. It switches modes only inside a reset row of its vector table. It supplies each read word in the cycle after the read command. `oe_i` is the one input moved in the middle of a cycle, and no property depends on it being stable.

// File: rtl/rop_pkg.sv
package rop_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_SPARE = 2'b11
  } rop_cmd_e;

  // The spare code is folded into a deselect at the capture point.
  function automatic rop_cmd_e rop_norm(input logic [1:0] raw);
    rop_cmd_e c;
    c = rop_cmd_e'(raw);
    if (c == CMD_SPARE) c = CMD_DESEL;
    return c;
  endfunction

endpackage

// File: rtl/rop_cmd_pipe.sv
module rop_cmd_pipe
  import rop_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic [1:0] cmd_i,
  output rop_cmd_e s1_o,
  output rop_cmd_e s2_o
);

  logic [STAGES-1:0][1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= CMD_DESEL;
        else        stg_q[g] <= rop_norm(cmd_i);
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= CMD_DESEL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign s1_o = rop_cmd_e'(stg_q[0]);
  assign s2_o = rop_cmd_e'(stg_q[1]);

endmodule

// File: rtl/rop_drive_ctl.sv
module rop_drive_ctl
  import rop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dcd_sel,
  input  rop_cmd_e s1_i,
  input  rop_cmd_e s2_i,
  output logic     drv_ft_o,
  output logic     drv_pl_o
);

  logic rd_now;
  logic hold_now;
  logic drv_pl_q;

  // Drive state when the output stage sits right after the capture register.
  always_comb begin
    rd_now   = (s1_i == CMD_READ);
    hold_now = dcd_sel && (s1_i == CMD_DESEL) && (s2_i == CMD_READ);
    drv_ft_o = rd_now || hold_now;
  end

  // Pipelined mode sees the same decision one edge later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_pl_q <= 1'b0;
    else        drv_pl_q <= drv_ft_o;
  end

  assign drv_pl_o = drv_pl_q;

  // R6: a write in the early stage forbids the flow-through drive state
  a_r6_write_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_i == CMD_WRITE) |-> !drv_ft_o);

endmodule

// File: rtl/rop_data_path.sv
module rop_data_path #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_live,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] ft_data_o,
  output logic [DATA_W-1:0] pl_data_o
);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] pl_q;

  // The last array word is kept so a dual-cycle hold can repeat it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (rd_live) hold_q <= rd_word;
  end

  assign ft_data_o = rd_live ? rd_word : hold_q;

  // Output register used in pipelined mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pl_q <= '0;
    else        pl_q <= ft_data_o;
  end

  assign pl_data_o = pl_q;

endmodule

// File: rtl/rop_read_out.sv
module rop_read_out
  import rop_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_sel,
  input  logic              dcd_sel,
  input  logic              oe_i,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_en
);

  rop_cmd_e          s1;
  rop_cmd_e          s2;
  logic              drv_ft;
  logic              drv_pl;
  logic [DATA_W-1:0] ft_data;
  logic [DATA_W-1:0] pl_data;
  logic              drive_sync;
  logic [DATA_W-1:0] data_sel;

  rop_cmd_pipe #(.STAGES(2)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_i (cmd_i),
    .s1_o  (s1),
    .s2_o  (s2)
  );

  rop_drive_ctl u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .dcd_sel  (dcd_sel),
    .s1_i     (s1),
    .s2_i     (s2),
    .drv_ft_o (drv_ft),
    .drv_pl_o (drv_pl)
  );

  rop_data_path #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_live   (s1 == CMD_READ),
    .rd_word   (rd_word),
    .ft_data_o (ft_data),
    .pl_data_o (pl_data)
  );

  always_comb begin
    drive_sync = pipe_sel ? drv_pl  : drv_ft;
    data_sel   = pipe_sel ? pl_data : ft_data;
    dq_en      = drive_sync & oe_i;
    dq_o       = dq_en ? data_sel : '0;
  end

  // R3: flow-through read drives in the next cycle, carrying the live word
  a_r3_ft_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_sel && cmd_i == CMD_READ) |=> (dq_en == oe_i));
  a_r3_ft_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_sel && cmd_i == CMD_READ) |=> (!dq_en || dq_o == rd_word));
  // R4: pipelined read drives one cycle later
  a_r4_pl_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_sel && cmd_i == CMD_READ) |=> ##1 (dq_en == oe_i));
  // R6: a write never drives the bus
  a_r6_ft_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_sel && cmd_i == CMD_WRITE) |=> !dq_en);
  a_r6_pl_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_sel && cmd_i == CMD_WRITE) |=> ##1 !dq_en);
  // R7: single-cycle deselect in flow-through turns the bus off at once
  a_r7_scd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_sel && !dcd_sel && cmd_i == CMD_DESEL) |=> !dq_en);

endmodule

// File: tb/rop_read_out_bench.sv
module rop_read_out_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NV = 39;

  typedef struct packed {
    logic         rs;
    logic         pipe;
    logic         dcd;
    logic [1:0]   cmd;
    logic [W-1:0] w;
    logic         oe;
    logic         en;
    logic [W-1:0] dq;
    logic [3:0]   rq;
  } vec_t;

  localparam logic [1:0] D = 2'b00, RD = 2'b01, WR = 2'b10, SP = 2'b11;

  // rs pipe dcd cmd word oe | en dq | requirement
  localparam vec_t VEC [NV] = '{
    // flow-through, single-cycle deselect
    '{1'b1,1'b0,1'b0,D ,16'h0000,1'b1,1'b0,16'h0000,4'd1},  // R1
    '{1'b0,1'b0,1'b0,RD,16'h0000,1'b1,1'b0,16'h0000,4'd1},  // R1
    '{1'b0,1'b0,1'b0,RD,16'h1111,1'b1,1'b1,16'h1111,4'd3},  // R3
    '{1'b0,1'b0,1'b0,RD,16'h2222,1'b1,1'b1,16'h2222,4'd5},  // R5
    '{1'b0,1'b0,1'b0,RD,16'h3333,1'b1,1'b1,16'h3333,4'd5},
    '{1'b0,1'b0,1'b0,D ,16'h4444,1'b1,1'b1,16'h4444,4'd5},
    '{1'b0,1'b0,1'b0,WR,16'h0E0E,1'b1,1'b0,16'h0000,4'd7},  // R7
    '{1'b0,1'b0,1'b0,RD,16'h0F0F,1'b1,1'b0,16'h0000,4'd6},  // R6
    '{1'b0,1'b0,1'b0,D ,16'h6666,1'b1,1'b1,16'h6666,4'd9},  // R9
    '{1'b0,1'b0,1'b0,SP,16'h7777,1'b1,1'b0,16'h0000,4'd7},
    '{1'b0,1'b0,1'b0,D ,16'h0000,1'b1,1'b0,16'h0000,4'd2},  // R2
    // flow-through, dual-cycle deselect
    '{1'b1,1'b0,1'b1,D ,16'h0000,1'b1,1'b0,16'h0000,4'd1},
    '{1'b0,1'b0,1'b1,RD,16'h0000,1'b1,1'b0,16'h0000,4'd1},
    '{1'b0,1'b0,1'b1,D ,16'h1234,1'b1,1'b1,16'h1234,4'd3},
    '{1'b0,1'b0,1'b1,D ,16'h9999,1'b1,1'b1,16'h1234,4'd8},  // R8 hold
    '{1'b0,1'b0,1'b1,RD,16'h9999,1'b1,1'b0,16'h0000,4'd8},
    '{1'b0,1'b0,1'b1,WR,16'h5678,1'b1,1'b1,16'h5678,4'd9},
    '{1'b0,1'b0,1'b1,D ,16'h0000,1'b1,1'b0,16'h0000,4'd6},
    '{1'b0,1'b0,1'b1,RD,16'h0000,1'b1,1'b0,16'h0000,4'd6},
    '{1'b0,1'b0,1'b1,SP,16'hABCD,1'b0,1'b0,16'h0000,4'd10}, // R10
    '{1'b0,1'b0,1'b1,D ,16'h0000,1'b1,1'b1,16'hABCD,4'd2},
    '{1'b0,1'b0,1'b1,D ,16'h0000,1'b1,1'b0,16'h0000,4'd8},
    // pipelined, single-cycle deselect
    '{1'b1,1'b1,1'b0,D ,16'h0000,1'b1,1'b0,16'h0000,4'd1},
    '{1'b0,1'b1,1'b0,RD,16'h0000,1'b1,1'b0,16'h0000,4'd4},  // R4
    '{1'b0,1'b1,1'b0,RD,16'h1111,1'b1,1'b0,16'h0000,4'd5},
    '{1'b0,1'b1,1'b0,RD,16'h2222,1'b1,1'b1,16'h1111,4'd4},
    '{1'b0,1'b1,1'b0,RD,16'h3333,1'b1,1'b1,16'h2222,4'd5},
    '{1'b0,1'b1,1'b0,D ,16'h4444,1'b1,1'b1,16'h3333,4'd5},
    '{1'b0,1'b1,1'b0,WR,16'h0000,1'b1,1'b1,16'h4444,4'd5},
    '{1'b0,1'b1,1'b0,D ,16'h0000,1'b1,1'b0,16'h0000,4'd7},
    '{1'b0,1'b1,1'b0,D ,16'h0000,1'b1,1'b0,16'h0000,4'd6},
    // pipelined, dual-cycle deselect
    '{1'b1,1'b1,1'b1,D ,16'h0000,1'b1,1'b0,16'h0000,4'd1},
    '{1'b0,1'b1,1'b1,RD,16'h0000,1'b1,1'b0,16'h0000,4'd4},
    '{1'b0,1'b1,1'b1,D ,16'h0AAA,1'b1,1'b0,16'h0000,4'd4},
    '{1'b0,1'b1,1'b1,RD,16'h0000,1'b1,1'b1,16'h0AAA,4'd4},
    '{1'b0,1'b1,1'b1,D ,16'h0BBB,1'b1,1'b1,16'h0AAA,4'd8},
    '{1'b0,1'b1,1'b1,D ,16'h0000,1'b1,1'b1,16'h0BBB,4'd9},
    '{1'b0,1'b1,1'b1,D ,16'h0000,1'b1,1'b1,16'h0BBB,4'd8},
    '{1'b0,1'b1,1'b1,D ,16'h0000,1'b1,1'b0,16'h0000,4'd8}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pipe_sel = 1'b0;
  logic         dcd_sel = 1'b0;
  logic         oe_i = 1'b1;
  logic [1:0]   cmd_i = D;
  logic [W-1:0] rd_word = '0;
  logic [W-1:0] dq_o;
  logic         dq_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rop_read_out #(.DATA_W(W)) u_rop_read_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .pipe_sel (pipe_sel),
    .dcd_sel  (dcd_sel),
    .oe_i     (oe_i),
    .cmd_i    (cmd_i),
    .rd_word  (rd_word),
    .dq_o     (dq_o),
    .dq_en    (dq_en)
  );

  task automatic check(input logic en_x, input logic [W-1:0] dq_x, input int rq);
    checks++;
    if (dq_en !== en_x || dq_o !== dq_x) begin
      errors++;
      $display("FAIL R%0d at %0t: en=%b dq=%h expected en=%b dq=%h",
               rq, $time, dq_en, dq_o, en_x, dq_x);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [W-1:0] w, input logic oe);
    @(negedge clk);
    cmd_i = c;
    rd_word = w;
    oe_i = oe;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rst_n    = ~VEC[i].rs;
      pipe_sel = VEC[i].pipe;
      dcd_sel  = VEC[i].dcd;
      cmd_i    = VEC[i].cmd;
      rd_word  = VEC[i].w;
      oe_i     = VEC[i].oe;
      #1;
      check(VEC[i].en, VEC[i].dq, int'(VEC[i].rq));
    end

    // R10: output enable acts inside a cycle, flow-through read
    @(negedge clk);
    rst_n = 1'b0; pipe_sel = 1'b0; dcd_sel = 1'b0; cmd_i = D;
    #1 check(1'b0, '0, 1);
    step(RD, '0, 1'b1);
    rst_n = 1'b1;
    step(D, 16'h5A5A, 1'b1);
    check(1'b1, 16'h5A5A, 3);
    #2 oe_i = 1'b0;
    #1 check(1'b0, '0, 10);
    oe_i = 1'b1;
    #1 check(1'b1, 16'h5A5A, 10);

    // R1: reset in the middle of a pipelined read clears the bus at once
    @(negedge clk);
    rst_n = 1'b0; pipe_sel = 1'b1; cmd_i = D;
    #1;
    step(D, '0, 1'b1);
    rst_n = 1'b1;
    step(RD, '0, 1'b1);
    step(D, 16'h1357, 1'b1);
    check(1'b0, '0, 4);
    step(D, '0, 1'b1);
    check(1'b1, 16'h1357, 4);
    #1 rst_n = 1'b0;
    #1 check(1'b0, '0, 1);
    step(D, '0, 1'b1);
    check(1'b0, '0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule